// File: doc/BRIEF.md
# Message-Signalled Interrupt Register Bank

A doorbell interrupt aggregator. An agent rings the block by writing one data word to its message register. The block decodes that word into a status register number and a bit position, then sets that bit. Each status register is 32 bits wide. Each drives one level interrupt line, which stays high while the register holds any pending bit. The service routine reads the status register. That read returns the pending bits and clears them in the same access, so no end-of-interrupt write is needed.

Two field layouts of the message word can be chosen with a mode pin. A second pin reverses the byte order of the message word before decoding; this lets software work around an endian fault. Decoding takes one cycle. The decoded set reaches the status register one cycle after the write is accepted. A read of that register in the same cycle clears only the bits that the read returned.

Requests travel on a valid/ready channel. A request moves when `req_valid` and `req_ready` are both high. Only reads produce a response. The response is held stable until `rsp_ready` is high. While a response is held and `rsp_ready` is low, `req_ready` is low.

Top module: `msi_bank`

## Requirements
- R1: With `layout_alt` low, message bits [4:0] give the bit position and bits [31:5] give the status register number.
- R2: With `layout_alt` high, message bits [3:0] give the status register number and bits [8:4] give the bit position. Bits above 8 are ignored.
- R3: `irq_o[i]` is high exactly when status register i is non-zero. After reset all lines are low. A set raises its line two clock edges after the write is accepted.
- R4: A read of status register i returns its pending bits on `rsp_rdata` one cycle after acceptance. The same read clears those bits.
- R5: A message whose decoded register number is `NUM_REGS` or more is dropped and sets nothing.
- R6: If a decoded set and a read of the same register reach that register in the same cycle, the read returns the older bits and the new bit stays pending.
- R7: With `swap_bytes` high, the message word is decoded as {d[7:0], d[15:8], d[23:16], d[31:24]}.
- R8: With `ADDR_MAP`=0, status register i sits at byte address i*0x10 and the message register at 0x140. With `ADDR_MAP`=1 the spacing is 0x4 and the message register is at 0x38. A read of an address that is not a register, including a misaligned one, returns zero and clears nothing.
- R9: Writes to status registers have no effect. A read of the message register returns zero and changes nothing.
- R10: A response stays valid with stable data while `rsp_ready` is low. `req_ready` is low whenever a response is held and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout_alt | input | 1 | Selects the alternate message field layout |
| swap_bytes | input | 1 | Reverses the byte order of message data before decoding |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | NUM_REGS | One level interrupt per status register |

## Verification
The assertions assume that `rsp_ready` and the request fields are driven to known values after reset. They also assume the mode pins are steady while a request is presented. The bench changes request fields, `layout_alt` and `swap_bytes` only at falling edges, and changes `rsp_ready` just after rising edges. It checks the same-cycle set/clear case by sending a message write and a read of the same register on consecutive cycles. It also holds `rsp_ready` low over several cycles to exercise the back-pressure rules.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int BIT_W    = 5;
  localparam int REG_W    = 4;
  localparam int MAX_REGS = 1 << REG_W;

  typedef struct packed {
    logic             hit;
    logic [REG_W-1:0] reg_idx;
    logic [BIT_W-1:0] bit_idx;
  } msi_tgt_t;

  function automatic logic [DATA_W-1:0] byte_rev(input logic [DATA_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/msi_decode.sv
module msi_decode
  import msi_bank_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic [DATA_W-1:0] msg_data,
  input  logic              layout_alt,
  input  logic              swap_bytes,
  output msi_tgt_t          tgt
);
  logic [DATA_W-1:0]       word;
  logic [DATA_W-BIT_W-1:0] leg_reg;

  always_comb begin
    word    = swap_bytes ? byte_rev(msg_data) : msg_data;
    leg_reg = word[DATA_W-1:BIT_W];
    if (layout_alt) begin
      tgt.reg_idx = word[REG_W-1:0];
      tgt.bit_idx = word[REG_W+BIT_W-1:REG_W];
      tgt.hit     = DATA_W'(word[REG_W-1:0]) < DATA_W'(NUM_REGS);
    end else begin
      tgt.reg_idx = leg_reg[REG_W-1:0];
      tgt.bit_idx = word[BIT_W-1:0];
      tgt.hit     = DATA_W'(leg_reg) < DATA_W'(NUM_REGS);
    end
  end
endmodule

// File: rtl/msi_addr_map.sv
module msi_addr_map
  import msi_bank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ADDR_MAP = 0,
  parameter int NUM_REGS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_msg,
  output logic              is_stat,
  output logic [REG_W-1:0]  stat_idx
);
  localparam int STRIDE_LG = (ADDR_MAP == 0) ? 4 : 2;
  localparam int MSG_OFF   = (ADDR_MAP == 0) ? 'h140 : 'h38;

  logic [ADDR_W-1:0] slot;
  logic              aligned;

  always_comb begin
    is_msg   = (addr == ADDR_W'(MSG_OFF));
    slot     = addr >> STRIDE_LG;
    aligned  = (addr[STRIDE_LG-1:0] == '0);
    is_stat  = !is_msg && aligned && (slot < ADDR_W'(NUM_REGS));
    stat_idx = slot[REG_W-1:0];
  end
endmodule

// File: rtl/msi_status_reg.sv
module msi_status_reg #(
  parameter int WIDTH = 32,
  parameter int BIT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BIT_W-1:0] set_bit,
  input  logic             clr_en,
  output logic [WIDTH-1:0] q,
  output logic             irq
);
  logic [WIDTH-1:0] set_vec;

  always_comb begin
    set_vec = set_en ? (WIDTH'(1) << set_bit) : '0;
    irq     = |q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr_en ? '0 : q) | set_vec;
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !set_en |=> q == '0); // R4
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> q[$past(set_bit)]); // R6
endmodule

// File: rtl/msi_bank.sv
module msi_bank
  import msi_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 12,
  parameter int ADDR_MAP = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                layout_alt,
  input  logic                swap_bytes,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [NUM_REGS-1:0] irq_o
);
  msi_tgt_t          tgt;
  logic              is_msg, is_stat;
  logic [REG_W-1:0]  stat_idx;
  logic              accept, msg_wr, rd;
  logic              pend_v;
  logic [REG_W-1:0]  pend_reg;
  logic [BIT_W-1:0]  pend_bit;
  logic [DATA_W-1:0] stat_q [NUM_REGS];
  logic [DATA_W-1:0] rd_val;

  msi_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .msg_data(req_wdata), .layout_alt(layout_alt),
    .swap_bytes(swap_bytes), .tgt(tgt));

  msi_addr_map #(.ADDR_W(ADDR_W), .ADDR_MAP(ADDR_MAP), .NUM_REGS(NUM_REGS)) u_map (
    .addr(req_addr), .is_msg(is_msg), .is_stat(is_stat), .stat_idx(stat_idx));

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    msg_wr    = accept && req_write && is_msg;
    rd        = accept && !req_write;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_reg <= '0;
      pend_bit <= '0;
    end else begin
      pend_v   <= msg_wr && tgt.hit;
      pend_reg <= tgt.reg_idx;
      pend_bit <= tgt.bit_idx;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stat
    msi_status_reg #(.WIDTH(DATA_W), .BIT_W(BIT_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .set_en(pend_v && (pend_reg == REG_W'(g))),
      .set_bit(pend_bit),
      .clr_en(rd && is_stat && (stat_idx == REG_W'(g))),
      .q(stat_q[g]),
      .irq(irq_o[g]));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (is_stat && stat_idx == REG_W'(i)) rd_val = stat_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R10
  AST_DROP_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_wr && !tgt.hit |=> !pend_v); // R5
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && !is_msg |=> !pend_v); // R9
  AST_NONSTATUS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !is_stat |=> rsp_rdata == '0); // R8
endmodule

// File: tb/msi_bank_test.sv
module msi_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam logic [11:0] MSG = 12'h140;

  logic clk = 0, rst_n = 0;
  logic layout_alt = 0, swap_bytes = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NR-1:0] irq_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [31:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_bank #(.NUM_REGS(NR), .ADDR_W(12), .ADDR_MAP(0)) uut (
    .clk(clk), .rst_n(rst_n), .layout_alt(layout_alt), .swap_bytes(swap_bytes),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq_o(irq_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses are consumed
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) chk(0, "unexpected response", rsp_rdata, 0);
      else begin
        automatic logic [31:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      chk(0, "watchdog", 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic req(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send(input logic [31:0] d);
    req(1, MSG, d); idle(); @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    expq.push_back(e); tagq.push_back(tag);
    req(0, a, 0); idle();
  endtask

  task automatic chk_irq(input logic [NR-1:0] e, input string tag);
    chk(irq_o == e, tag, 32'(irq_o), 32'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq_o == 0 && req_ready && !rsp_valid, "R3 R10 reset state", 32'(irq_o), 0);

    // R1 legacy decode: reg 3 bit 7
    send((32'd3 << 5) | 32'd7);
    chk_irq(8'h08, "R3 irq after set");
    rd(12'h030, 32'h80, "R1 R4 read reg3");
    chk_irq(8'h00, "R4 irq cleared by read");
    rd(12'h030, 32'h0, "R4 reread empty");

    send(32'd0); send(32'd31); send((32'd7 << 5) | 32'd5);
    chk_irq(8'h81, "R3 two lines");
    rd(12'h000, 32'h8000_0001, "R1 reg0 two bits");
    rd(12'h070, 32'h20, "R1 R8 reg7");

    // R5 out of range
    send((32'd8 << 5) | 32'd1);
    send(32'hFFFF_FFE0);
    chk_irq(8'h00, "R5 legacy dropped");

    // R2 alternate layout
    layout_alt = 1;
    send(32'hFFFF_F000 | (32'd12 << 4) | 32'd2);
    chk_irq(8'h04, "R2 alt set");
    rd(12'h020, 32'h1000, "R2 reg2 bit12");
    send((32'd3 << 4) | 32'd9);
    chk_irq(8'h00, "R5 alt dropped");
    layout_alt = 0;

    // R7 byte swap: decoded 0x24 -> reg1 bit4
    swap_bytes = 1;
    send(32'h2400_0000);
    swap_bytes = 0;
    rd(12'h010, 32'h10, "R7 swapped");

    // R9 status write ignored, message read zero
    req(1, 12'h020, 32'hFFFF_FFFF); idle(); @(negedge clk);
    chk_irq(8'h00, "R9 status write ignored");
    send((32'd4 << 5) | 32'd1);
    rd(MSG, 32'h0, "R9 message read zero");
    chk_irq(8'h10, "R9 message read no clear");
    rd(12'h040, 32'h2, "R9 reg4 intact");

    // R8 misaligned address
    send((32'd7 << 5) | 32'd2);
    rd(12'h074, 32'h0, "R8 misaligned zero");
    rd(12'h070, 32'h4, "R8 aligned reg7");

    // R6 set and clear in same cycle
    send((32'd5 << 5) | 32'd3);
    expq.push_back(32'h8); tagq.push_back("R6 read returns old bits");
    req(1, MSG, (32'd5 << 5) | 32'd9);
    req(0, 12'h050, 0);
    idle();
    @(negedge clk);
    chk_irq(8'h20, "R6 new bit pending");
    rd(12'h050, 32'h200, "R6 new bit read");

    // R10 back-pressure
    send((32'd6 << 5) | 32'd0);
    @(posedge clk); #1 rsp_ready = 0;
    expq.push_back(32'h1); tagq.push_back("R10 held response");
    req(0, 12'h060, 0); idle();
    chk(rsp_valid && !req_ready, "R10 blocked", {30'b0, rsp_valid, req_ready}, 32'h2);
    @(negedge clk); @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h1 && !req_ready, "R10 held stable", rsp_rdata, 32'h1);
    @(posedge clk); #1 rsp_ready = 1;
    @(negedge clk); @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 released", {30'b0, rsp_valid, req_ready}, 32'h1);
    chk_irq(8'h00, "R4 reg6 cleared");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "responses all seen", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule